// File: doc/BRIEF.md
# Antenna Tuning Table Lookup

This block keeps a table of relay settings for an automatic antenna matcher. The table has one row per frequency segment and one column per antenna. Each cell is four bytes long and sits in a byte-wide array that stands in for a nonvolatile store. Every byte in the array starts at all ones, and a cell in that state counts as empty. A cell holds a relay image and a presence marker. The marker is active low, so an erased cell reads as holding no data.

To run a lookup, the caller gives a segment index. The block reads all the cells of that row, one byte per cycle. When more than one antenna has an entry, it picks the antenna used most recently. It then reports whether an entry was found, which antenna was chosen, and that antenna's relay image. A write request stores a new relay image for a given segment and antenna, and the same write marks the cell as present. The block handles one operation at a time.

Top module: `tune_table`

## Requirements
- R1: After synchronous reset, `busy`, `lk_done`, `wr_done` and `lk_hit` are 0, and `lk_ant` and `lk_pattern` are zero.
- R2: A lookup on a row with no present cell reports a miss: `lk_hit`=0, with `lk_ant` and `lk_pattern` all zeros.
- R3: A cell is stored as four consecutive bytes, least significant byte first. Bits 29..0 hold the relay image, bit 30 is kept at 1, and bit 31 is the presence marker (0 = present, so an all-ones cell is empty). After a write, a lookup of that segment returns `lk_hit`=1 with that antenna and image.
- R4: When several antennas of a row are present and the last-used antenna is one of them, the last-used antenna is chosen.
- R5: When the last-used antenna has no entry in the row, the lowest-numbered present antenna is chosen.
- R6: The last-used antenna becomes the antenna of each completed write and of each lookup hit. A miss leaves it unchanged. Reset sets it to 0.
- R7: `lk_done` rises 18 rising edges after the edge that accepts `lk_start`. `wr_done` rises 4 edges after the edge that accepts `wr_start`.
- R8: `lk_done` and `wr_done` are one-cycle pulses. `busy` is 1 from acceptance until the operation's done pulse, and it is 0 while `lk_done` is high.
- R9: A `lk_start` or `wr_start` that arrives while `busy` is 1 is ignored.
- R10: If `wr_start` and `lk_start` arrive in the same idle cycle, the write runs first (`wr_done` at edge 4). The lookup follows and sees the new data (`lk_done` at edge 22).
- R11: A write to one segment leaves every other segment unchanged.
- R12: Writing an already present cell replaces its relay image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_start | input | 1 | Request a lookup |
| lk_seg | input | SEG_W | Segment index for the lookup |
| wr_start | input | 1 | Request a write |
| wr_seg | input | SEG_W | Segment index for the write |
| wr_ant | input | ANT_W | Antenna column for the write |
| wr_pattern | input | PAT_W | Relay image to store |
| busy | output | 1 | An operation is in progress |
| lk_done | output | 1 | Lookup result valid (pulse) |
| lk_hit | output | 1 | A present entry was found |
| lk_ant | output | ANT_W | Chosen antenna |
| lk_pattern | output | PAT_W | Relay image of the chosen antenna |
| wr_done | output | 1 | Write finished (pulse) |

## Verification
A write and a lookup can be requested in the same cycle, and both target the same cell. The bench raises `wr_start` and `lk_start` together on one idle edge, aimed at one segment and antenna. It counts edges to each done pulse and expects 4 and 22. The lookup is judged correct only if it returns the image that was just written; if it had run before the write, it would report a miss. A second case issues a write while a lookup is in progress and then confirms the write never happened.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_LOOK, ST_FINISH} tune_state_t;
  localparam int BYTE_W     = 8;
  localparam int CELL_BYTES = 4;
  localparam int CELL_W     = BYTE_W * CELL_BYTES;
endpackage

// File: rtl/tune_byte_ram.sv
module tune_byte_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  // erased store: every byte all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tune_pick.sv
module tune_pick #(
  parameter int NUM_ANT = 4,
  parameter int ANT_W   = 2
) (
  input  logic [NUM_ANT-1:0] valid,
  input  logic [ANT_W-1:0]   last,
  output logic               hit,
  output logic [ANT_W-1:0]   sel
);
  always_comb begin
    hit = |valid;
    sel = '0;
    for (int i = NUM_ANT - 1; i >= 0; i--) begin
      if (valid[i]) sel = ANT_W'(i);
    end
    if (valid[last]) sel = last;
  end
endmodule

// File: rtl/tune_table.sv
module tune_table
  import tune_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int NUM_ANT = 4,
  parameter int PAT_W   = 30,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int ANT_W  = $clog2(NUM_ANT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_start,
  input  logic [SEG_W-1:0] lk_seg,
  input  logic             wr_start,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [ANT_W-1:0] wr_ant,
  input  logic [PAT_W-1:0] wr_pattern,
  output logic             busy,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [ANT_W-1:0] lk_ant,
  output logic [PAT_W-1:0] lk_pattern,
  output logic             wr_done
);
  localparam int POS_W     = ANT_W + 2;
  localparam int ROW_STEPS = NUM_ANT * CELL_BYTES;
  localparam int STEP_W    = $clog2(ROW_STEPS + 1);
  localparam int ADDR_W    = SEG_W + POS_W;
  localparam int DEPTH     = NUM_SEG * ROW_STEPS;
  localparam int SPARE_W   = CELL_W - 1 - PAT_W;

  tune_state_t       state;
  logic [STEP_W-1:0] idx;
  logic [SEG_W-1:0]  lseg_q, wseg_q;
  logic [ANT_W-1:0]  want_q, last_q;
  logic [CELL_W-1:0] wword_q;
  logic              pend_q;
  logic [23:0]       acc;
  logic              rd_valid_q;
  logic [POS_W-1:0]  rd_pos_q;
  logic [NUM_ANT-1:0] col_valid;
  logic [PAT_W-1:0]  col_pat [NUM_ANT];

  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_wdata, ram_rdata;
  logic [CELL_W-1:0] cur_word;
  logic              pick_hit;
  logic [ANT_W-1:0]  pick_sel;

  assign busy     = (state != ST_IDLE);
  assign cur_word = {ram_rdata, acc};

  always_comb begin
    ram_we    = (state == ST_WRITE);
    ram_wdata = wword_q[idx[1:0]*8 +: 8];
    if (state == ST_WRITE) ram_addr = {wseg_q, want_q, idx[1:0]};
    else                   ram_addr = {lseg_q, idx[POS_W-1:0]};
  end

  tune_byte_ram #(.DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  tune_pick #(.NUM_ANT(NUM_ANT), .ANT_W(ANT_W)) u_pick (
    .valid(col_valid), .last(last_q), .hit(pick_hit), .sel(pick_sel)
  );

  // read-data tracking and column assembly
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_pos_q   <= '0;
      acc        <= '0;
      col_valid  <= '0;
    end else begin
      rd_valid_q <= (state == ST_LOOK) && (idx != STEP_W'(ROW_STEPS));
      rd_pos_q   <= idx[POS_W-1:0];
      if (rd_valid_q) begin
        acc <= {ram_rdata, acc[23:8]};
        if (rd_pos_q[1:0] == 2'd3) begin
          col_valid[rd_pos_q[POS_W-1:2]] <= ~cur_word[CELL_W-1];
          col_pat[rd_pos_q[POS_W-1:2]]   <= cur_word[PAT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      pend_q     <= 1'b0;
      last_q     <= '0;
      lseg_q     <= '0;
      wseg_q     <= '0;
      want_q     <= '0;
      wword_q    <= '1;
      lk_done    <= 1'b0;
      wr_done    <= 1'b0;
      lk_hit     <= 1'b0;
      lk_ant     <= '0;
      lk_pattern <= '0;
    end else begin
      lk_done <= 1'b0;
      wr_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (wr_start) begin
            wseg_q  <= wr_seg;
            want_q  <= wr_ant;
            wword_q <= {1'b0, {SPARE_W{1'b1}}, wr_pattern};
            pend_q  <= lk_start;
            if (lk_start) lseg_q <= lk_seg;
            state   <= ST_WRITE;
          end else if (lk_start) begin
            lseg_q <= lk_seg;
            state  <= ST_LOOK;
          end
        end
        ST_WRITE: begin
          if (idx == STEP_W'(CELL_BYTES - 1)) begin
            wr_done <= 1'b1;
            last_q  <= want_q;
            idx     <= '0;
            pend_q  <= 1'b0;
            state   <= pend_q ? ST_LOOK : ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_LOOK: begin
          if (idx == STEP_W'(ROW_STEPS)) state <= ST_FINISH;
          else                           idx   <= idx + 1'b1;
        end
        ST_FINISH: begin
          lk_done    <= 1'b1;
          lk_hit     <= pick_hit;
          lk_ant     <= pick_hit ? pick_sel : '0;
          lk_pattern <= pick_hit ? col_pat[pick_sel] : '0;
          if (pick_hit) last_q <= pick_sel;
          idx   <= '0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_table_chk.sv
module tune_table_chk #(
  parameter int ANT_W = 2,
  parameter int PAT_W = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             lk_done,
  input logic             lk_hit,
  input logic [ANT_W-1:0] lk_ant,
  input logic [PAT_W-1:0] lk_pattern,
  input logic             wr_done
);
  AST_LK_PULSE: assert property (@(posedge clk) disable iff (rst) lk_done |=> !lk_done); // R8
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst) wr_done |=> !wr_done); // R8
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst) lk_done |-> !busy); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> (lk_pattern == '0 && lk_ant == '0)); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(lk_pattern) |-> lk_done); // R3
  AST_DONE_APART: assert property (@(posedge clk) disable iff (rst) !(lk_done && wr_done)); // R10
endmodule

bind tune_table tune_table_chk #(.ANT_W(ANT_W), .PAT_W(PAT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .lk_done(lk_done), .lk_hit(lk_hit),
  .lk_ant(lk_ant), .lk_pattern(lk_pattern), .wr_done(wr_done)
);

// File: tb/tb_tune_table.sv
`timescale 1ns/1ps
module tb_tune_table;
  localparam int SEG_W = 4;
  localparam int ANT_W = 2;
  localparam int PAT_W = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_start = 1'b0, wr_start = 1'b0;
  logic [SEG_W-1:0] lk_seg = '0, wr_seg = '0;
  logic [ANT_W-1:0] wr_ant = '0;
  logic [PAT_W-1:0] wr_pattern = '0;
  logic busy, lk_done, lk_hit, wr_done;
  logic [ANT_W-1:0] lk_ant;
  logic [PAT_W-1:0] lk_pattern;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tune_table dut (
    .clk(clk), .rst(rst), .lk_start(lk_start), .lk_seg(lk_seg),
    .wr_start(wr_start), .wr_seg(wr_seg), .wr_ant(wr_ant), .wr_pattern(wr_pattern),
    .busy(busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_ant(lk_ant),
    .lk_pattern(lk_pattern), .wr_done(wr_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [SEG_W-1:0] s, input logic [ANT_W-1:0] a,
                          input logic [PAT_W-1:0] p, input string req);
    int cnt;
    @(negedge clk);
    wr_start = 1'b1; wr_seg = s; wr_ant = a; wr_pattern = p;
    @(posedge clk);
    @(negedge clk);
    wr_start = 1'b0;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (wr_done) break;
    end
    chk(cnt == 4, {req, " R7 write latency"}, cnt, 4);
  endtask

  task automatic do_lookup(input logic [SEG_W-1:0] s, input bit exp_hit,
                           input logic [ANT_W-1:0] exp_ant, input logic [PAT_W-1:0] exp_pat,
                           input string req);
    int cnt;
    @(negedge clk);
    lk_start = 1'b1; lk_seg = s;
    @(posedge clk);
    @(negedge clk);
    lk_start = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (lk_done) break;
    end
    chk(cnt == 18, "R7 lookup latency", cnt, 18);
    chk(lk_hit == exp_hit, {req, " hit"}, lk_hit, exp_hit);
    chk(lk_ant == exp_ant, {req, " antenna"}, lk_ant, exp_ant);
    chk(lk_pattern == exp_pat, {req, " pattern"}, lk_pattern, exp_pat);
    @(negedge clk);
    chk(lk_done == 1'b0, "R8 done pulse width", lk_done, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 0 && lk_done == 0 && wr_done == 0 && lk_hit == 0, "R1 flags", {busy, lk_done, wr_done, lk_hit}, 0);
    chk(lk_ant == 0 && lk_pattern == 0, "R1 outputs", lk_pattern, 0);
  endtask

  task automatic t_erased;
    do_lookup(4'd5, 1'b0, 2'd0, '0, "R2 erased row");
  endtask

  task automatic t_write_read;
    do_write(4'd3, 2'd2, 30'h1543F2D6, "R3");
    do_lookup(4'd3, 1'b1, 2'd2, 30'h1543F2D6, "R3 stored cell");
  endtask

  task automatic t_prefer;
    do_write(4'd7, 2'd1, 30'h0AAAA001, "R4");
    do_write(4'd7, 2'd3, 30'h0BBBB003, "R4");
    do_lookup(4'd7, 1'b1, 2'd3, 30'h0BBBB003, "R4 last used 3");
    do_write(4'd9, 2'd1, 30'h0CCCC001, "R6");
    do_lookup(4'd7, 1'b1, 2'd1, 30'h0AAAA001, "R4 last used 1");
  endtask

  task automatic t_fallback;
    do_write(4'd10, 2'd3, 30'h0DDDD003, "R5");
    do_write(4'd10, 2'd2, 30'h0EEEE002, "R5");
    do_write(4'd11, 2'd0, 30'h0FFFF000, "R5");
    do_lookup(4'd10, 1'b1, 2'd2, 30'h0EEEE002, "R5 lowest present");
    do_lookup(4'd7, 1'b1, 2'd1, 30'h0AAAA001, "R6 hit updates last");
  endtask

  task automatic t_miss_keeps;
    do_write(4'd13, 2'd3, 30'h01234567, "R6");
    do_lookup(4'd12, 1'b0, 2'd0, '0, "R2 empty row");
    do_lookup(4'd7, 1'b1, 2'd3, 30'h0BBBB003, "R6 miss keeps last");
  endtask

  task automatic t_busy_ignore;
    bit seen_wr;
    @(negedge clk);
    lk_start = 1'b1; lk_seg = 4'd3;
    @(posedge clk);
    @(negedge clk);
    lk_start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R8 busy mid lookup", busy, 1);
    wr_start = 1'b1; wr_seg = 4'd14; wr_ant = 2'd0; wr_pattern = 30'h3FFF0000;
    lk_start = 1'b1; lk_seg = 4'd14;
    @(negedge clk);
    wr_start = 1'b0; lk_start = 1'b0;
    seen_wr = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wr_done) seen_wr = 1;
      if (lk_done) break;
    end
    chk(lk_hit == 1 && lk_ant == 2'd2, "R9 first lookup result", {lk_hit, lk_ant}, 3'b110);
    repeat (3) @(negedge clk);
    chk(seen_wr == 0 && busy == 0, "R9 no write started", {seen_wr, busy}, 0);
    do_lookup(4'd14, 1'b0, 2'd0, '0, "R9 ignored write");
  endtask

  task automatic t_simul;
    int cnt, wcnt, lcnt;
    @(negedge clk);
    wr_start = 1'b1; wr_seg = 4'd15; wr_ant = 2'd1; wr_pattern = 30'h2468ACE1;
    lk_start = 1'b1; lk_seg = 4'd15;
    @(posedge clk);
    @(negedge clk);
    wr_start = 1'b0; lk_start = 1'b0;
    cnt = 0; wcnt = 0; lcnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (wr_done) wcnt = cnt;
      if (lk_done) begin lcnt = cnt; break; end
    end
    chk(wcnt == 4, "R10 write first", wcnt, 4);
    chk(lcnt == 22, "R10 lookup after", lcnt, 22);
    chk(lk_hit == 1 && lk_ant == 2'd1, "R10 sees new cell", {lk_hit, lk_ant}, 3'b101);
    chk(lk_pattern == 30'h2468ACE1, "R10 pattern", lk_pattern, 30'h2468ACE1);
  endtask

  task automatic t_segments;
    do_lookup(4'd2, 1'b0, 2'd0, '0, "R11 neighbour below");
    do_lookup(4'd4, 1'b0, 2'd0, '0, "R11 neighbour above");
  endtask

  task automatic t_rewrite;
    do_write(4'd3, 2'd2, 30'h00C0FFEE, "R12");
    do_lookup(4'd3, 1'b1, 2'd2, 30'h00C0FFEE, "R12 replaced");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_erased();
    t_write_read();
    t_prefer();
    t_fallback();
    t_miss_keeps();
    t_busy_ignore();
    t_simul();
    t_segments();
    t_rewrite();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule